// File: doc/BRIEF.md
# ADC Trigger and Clock Sequencer

This block decides the cycle in which an analog-to-digital conversion begins, and it produces the clock enable that paces the converter. The system clock is divided by a factor that a 3-bit code selects. Software can start a conversion by hand. In auto mode, a 3-bit code instead picks one of eight flag inputs, and a rising edge on the picked flag launches a conversion.

The edge is detected after the flag multiplexer. Moving the select from a low flag to a high flag is therefore an edge. Selecting code 0 (free-running, fed by the conversion-complete flag) is never an edge, even when that flag is already high. Once a conversion has started, the block reports busy until the converter signals done. Any start request that arrives while busy is dropped.

Top module: `adc_trig_seq`

## Requirements
- R1: `psc_sel` codes 0..7 give division factors 2, 2, 4, 8, 16, 32, 64, 128. `adc_clk_en` is high for exactly one cycle in every factor cycles.
- R2: While `conv_en` is low, `adc_clk_en` stays low and the divider is cleared. After `conv_en` goes high, the first pulse appears at the edge that is the factor-th edge to see `conv_en` high.
- R3: A `man_start` sampled while `conv_en` is high and the block is idle gives `start_pulse` high for one cycle. `busy` goes high from that same edge.
- R4: With `auto_en` high, a rising edge on `trig_flags[trig_sel]` starts a conversion at the next edge. Bit 0 is the conversion-complete flag, used by code 0.
- R5: While `auto_en` is low, `trig_sel` and `trig_flags` never cause a start.
- R6: Changing `trig_sel` from a low flag to a high flag counts as a rising edge and starts a conversion.
- R7: Changing `trig_sel` to code 0 never starts a conversion, even if `trig_flags[0]` is already high.
- R8: While `conv_en` is low, no start is issued and `busy` is cleared.
- R9: While `busy` is high, trigger edges and `man_start` are ignored. `conv_done` clears `busy` at the next edge.
- R10: A selected flag held high does not retrigger. Only a low-to-high change of the multiplexer output counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Converter enable |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | 3 | Trigger source code (0 = free-running) |
| trig_flags | input | 8 | Trigger flags; bit 0 is conversion-complete |
| psc_sel | input | 3 | Prescaler code |
| man_start | input | 1 | Manual start request |
| conv_done | input | 1 | Converter finished |
| start_pulse | output | 1 | One-cycle conversion start |
| busy | output | 1 | Conversion in progress |
| adc_clk_en | output | 1 | Converter clock enable |

## Verification
`start_pulse` and `busy` both change at the first clock edge that samples the causing inputs. This holds because the edge detector compares the live multiplexer output with a copy registered on the previous edge. The bench drives inputs just after an edge. It predicts the outcome of the next edge from its own model of the previous flag, the previous select and busy, and it compares 2 ns after that edge. For the clock enable, the bench counts the edges since `conv_en` was first sampled high and expects a pulse exactly on every multiple of the factor.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int CNT_W   = 7;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam sel_t SEL_FREE = '0;

    typedef struct packed {
        logic manual;
        logic auto_edge;
    } start_req_t;

    // terminal count (factor - 1) for a prescaler code
    function automatic cnt_t div_limit(input sel_t code);
        int unsigned d;
        d = (code == SEL_FREE) ? 32'd2 : (32'd1 << code);
        return cnt_t'(d - 32'd1);
    endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  sel_t psc_sel,
    output logic tick
);
    cnt_t cnt;
    cnt_t lim;

    assign lim = div_limit(psc_sel);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    a_r1_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    a_r2_cleared_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!tick && cnt == '0));
endmodule

// File: rtl/adc_trig_detect.sv
module adc_trig_detect
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  sel_t               sel,
    input  logic [NUM_SRC-1:0] flags,
    output logic               edge_det
);
    logic mux;
    logic prev;
    sel_t sel_q;
    logic newly_free;

    assign mux        = flags[sel];
    assign newly_free = (sel == SEL_FREE) && (sel_q != SEL_FREE);
    assign edge_det   = mux && !prev && !newly_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            sel_q <= SEL_FREE;
        end else begin
            prev  <= mux;
            sel_q <= sel;
        end
    end

    a_r7_free_select_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sel == SEL_FREE && $past(sel) != SEL_FREE) |-> !edge_det);
    a_r10_level_no_edge: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(sel) && $past(mux)) |-> !edge_det);
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic conv_en,
    input  logic auto_en,
    input  logic man_start,
    input  logic edge_det,
    input  logic conv_done,
    output logic start_pulse,
    output logic busy
);
    start_req_t req;
    logic       go;

    assign req.manual    = man_start;
    assign req.auto_edge = auto_en && edge_det;
    assign go            = conv_en && !busy && (req.manual || req.auto_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pulse <= 1'b0;
            busy        <= 1'b0;
        end else begin
            start_pulse <= go;
            if (!conv_en)       busy <= 1'b0;
            else if (go)        busy <= 1'b1;
            else if (conv_done) busy <= 1'b0;
        end
    end

    a_r3_busy_on_start: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> busy);
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);
    a_r8_disabled: assert property (@(posedge clk) disable iff (rst)
        !conv_en |=> (!start_pulse && !busy));
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_en && !conv_done) |=> (busy && !start_pulse));
    a_r5_no_auto: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !man_start) |=> !start_pulse);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               conv_en,
    input  logic               auto_en,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic [NUM_SRC-1:0] trig_flags,
    input  logic [SEL_W-1:0]   psc_sel,
    input  logic               man_start,
    input  logic               conv_done,
    output logic               start_pulse,
    output logic               busy,
    output logic               adc_clk_en
);
    logic edge_det;

    adc_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .enable  (conv_en),
        .psc_sel (psc_sel),
        .tick    (adc_clk_en)
    );

    adc_trig_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .sel      (trig_sel),
        .flags    (trig_flags),
        .edge_det (edge_det)
    );

    adc_start_ctrl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .conv_en     (conv_en),
        .auto_en     (auto_en),
        .man_start   (man_start),
        .edge_det    (edge_det),
        .conv_done   (conv_done),
        .start_pulse (start_pulse),
        .busy        (busy)
    );
endmodule

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_en = 1'b0, auto_en = 1'b0, man_start = 1'b0, conv_done = 1'b0;
    logic [2:0] trig_sel = '0, psc_sel = '0;
    logic [7:0] trig_flags = '0;
    logic       start_pulse, busy, adc_clk_en;

    int checks = 0, errors = 0;
    logic m_prev = 1'b0, m_busy = 1'b0, exp_start = 1'b0;
    logic [2:0] m_sel = '0;

    always #4 clk = ~clk;

    adc_trig_seq i_adc_trig_seq (
        .clk(clk), .rst(rst), .conv_en(conv_en), .auto_en(auto_en),
        .trig_sel(trig_sel), .trig_flags(trig_flags), .psc_sel(psc_sel),
        .man_start(man_start), .conv_done(conv_done),
        .start_pulse(start_pulse), .busy(busy), .adc_clk_en(adc_clk_en)
    );

    function automatic int factor(input logic [2:0] c);
        return (c == 3'd0) ? 2 : (1 << c);
    endfunction

    task automatic chk(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    // predict next edge from current inputs, advance, then compare
    task automatic step(input string tag);
        logic mux, edg, req;
        mux = trig_flags[trig_sel];
        edg = mux && !m_prev && !(trig_sel == 3'd0 && m_sel != 3'd0);
        req = conv_en && !m_busy && (man_start || (auto_en && edg));
        m_prev = mux;
        m_sel  = trig_sel;
        if (!conv_en) m_busy = 1'b0;
        else if (req) m_busy = 1'b1;
        else if (conv_done) m_busy = 1'b0;
        exp_start = req;
        @(posedge clk); #2;
        chk({tag, " start"}, start_pulse, exp_start);
        chk({tag, " busy"}, busy, m_busy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        chk("R8 reset start", start_pulse, 1'b0);
        chk("R8 reset busy", busy, 1'b0);
        chk("R2 reset clk_en", adc_clk_en, 1'b0);
        rst = 1'b0;
        step("R8 idle");

        // R3 manual start, R9 busy ignores start, done clears
        conv_en = 1'b1; man_start = 1'b1; step("R3 manual");
        chk("R3 pulse", start_pulse, 1'b1);
        man_start = 1'b0; step("R3 after");
        chk("R3 single", start_pulse, 1'b0);
        man_start = 1'b1; step("R9 manual while busy");
        chk("R9 ignored", start_pulse, 1'b0);
        man_start = 1'b0; conv_done = 1'b1; step("R9 done");
        chk("R9 cleared", busy, 1'b0);
        conv_done = 1'b0;

        // R4 rising edge on selected flag
        auto_en = 1'b1; trig_sel = 3'd3; step("R4 setup");
        trig_flags[3] = 1'b1; step("R4 edge");
        chk("R4 started", start_pulse, 1'b1);
        conv_done = 1'b1; step("R9 done2"); conv_done = 1'b0;
        step("R10 held high");
        chk("R10 no retrigger", start_pulse, 1'b0);

        // R6 switch low -> high source
        trig_flags = 8'b0000_0100; trig_sel = 3'd5; step("R6 setup");
        trig_sel = 3'd2; step("R6 switch");
        chk("R6 started", start_pulse, 1'b1);
        conv_done = 1'b1; step("R9 done3"); conv_done = 1'b0;

        // R7 switch to free-running with flag 0 high
        trig_flags = 8'b0000_0001; trig_sel = 3'd6; step("R7 setup");
        trig_sel = 3'd0; step("R7 switch");
        chk("R7 no start", start_pulse, 1'b0);
        step("R7 hold");
        trig_flags[0] = 1'b0; step("R4 free low");
        trig_flags[0] = 1'b1; step("R4 free edge");
        chk("R4 free-running start", start_pulse, 1'b1);
        conv_done = 1'b1; step("R9 done4"); conv_done = 1'b0;

        // R5 auto disabled
        auto_en = 1'b0; trig_flags = '0; trig_sel = 3'd4; step("R5 setup");
        trig_flags[4] = 1'b1; step("R5 edge");
        chk("R5 no start", start_pulse, 1'b0);
        chk("R5 still idle", busy, 1'b0);

        // R8 disabled: no start, busy cleared
        man_start = 1'b1; step("R8 start"); man_start = 1'b0;
        conv_en = 1'b0; step("R8 disable");
        chk("R8 busy cleared", busy, 1'b0);
        man_start = 1'b1; step("R8 manual off");
        chk("R8 no start", start_pulse, 1'b0);
        man_start = 1'b0;

        // R1/R2 prescaler factors
        for (int c = 0; c < 8; c++) begin
            conv_en = 1'b0; psc_sel = 3'(c); step("R2 off");
            chk("R2 off clk_en", adc_clk_en, 1'b0);
            conv_en = 1'b1;
            for (int n = 1; n <= 2 * factor(3'(c)); n++) begin
                step("R1 run");
                chk((n == factor(3'(c))) ? "R2 first pulse" : "R1 pacing",
                    adc_clk_en, (n % factor(3'(c))) == 0);
            end
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            conv_en   = ($urandom % 20) != 0;
            auto_en   = ($urandom % 4) != 0;
            man_start = ($urandom % 12) == 0;
            conv_done = ($urandom % 5) == 0;
            if ($urandom % 3 == 0) trig_sel = 3'($urandom);
            if ($urandom % 2 == 0) trig_flags = 8'($urandom);
            step("R4/R6/R7/R9 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule